// File: doc/BRIEF.md
# Grid Potential Relaxation Engine

This block solves for the steady-state potential across a square mesh of nodes by repeatedly replacing every interior node with the mean of its four orthogonal neighbours. The whole mesh sits in on-chip storage. The edge nodes hold fixed potentials. They reset to a default profile: 0 along the top edge, 20 along the bottom edge and 10 down both side edges. Software may overwrite them through a write port while the engine is idle.

A run begins with a start pulse. The start pulse zeroes the interior and captures the configuration: the update style, the scan direction, the convergence enable and the sweep limit. The update style is one of two:
- Buffered: each sweep reads only the previous sweep's values. Two banks swap roles at the end of every sweep.
- In place: each result is written straight back and is seen by the neighbours visited after it in the same sweep. These neighbours are visited in forward order (top row first, left to right) or in reverse order.

The engine updates one node per clock. When the run finishes, a one-cycle done pulse marks the end, and any node can then be read through the readout port.

Top module: `grid_relax`

## Requirements
- R1: Reset behaviour. After reset, busy and done are low. Readout address r*16+c (row r counted from the top, column c from the left) returns the following Q8.8 values:
  - 0x0000 on row 0;
  - 0x1400 on row 15;
  - 0x0A00 on columns 0 and 15 of the other rows;
  - 0x0000 at every interior node.
- R2: Edge writes while idle. While idle, a write to an edge-node address stores the data at that node. A write to an interior address changes nothing. Readout values do not change while idle without a write or a start.
- R3: Edge nodes never change during or after a run.
- R4: A start zeroes every interior node before the first sweep, whatever an earlier run left behind.
- R5: Averaging arithmetic. A new value is the sum of the north, south, east and west neighbours, with the sum shifted right by 2 (truncated). Values are unsigned Q8.8.
- R6: Buffered mode (mode_inplace = 0). Every new value of a sweep is computed from the values at the start of that sweep.
- R7: In-place forward mode (mode_inplace = 1, scan_rev = 0). Rows are visited top to bottom and columns left to right. Each new value is used at once by later nodes in the same sweep.
- R8: In-place reverse mode (scan_rev = 1). Rows are visited bottom to top and columns right to left.
- R9: Sweep count and timing. With conv_en = 0, the run performs max(iter_cnt, 1) sweeps of 196 cycles each. The done pulse appears exactly sweeps*196 cycles after the clock edge that accepts start. busy falls in the same cycle that done rises.
- R10: Convergence stop. With conv_en = 1, the run also stops after the first sweep in which no node changed by more than its old value shifted right by 10. iter_cnt still bounds the number of sweeps.
- R11: While busy, start, the configuration inputs and edge writes are ignored.
- R12: done is high for exactly one cycle and never together with busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted when idle) |
| mode_inplace | input | 1 | 1: in-place update, 0: buffered |
| scan_rev | input | 1 | 1: reverse visiting order |
| conv_en | input | 1 | Enable convergence stop |
| iter_cnt | input | 8 | Sweep limit (0 treated as 1) |
| bnd_we | input | 1 | Edge-node write strobe |
| bnd_addr | input | 8 | Node address row*16+col |
| bnd_data | input | 16 | Edge value, Q8.8 |
| rd_addr | input | 8 | Readout node address |
| rd_data | output | 16 | Readout value, Q8.8 |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions take two things for granted:
- The readout address is held steady whenever the bench wants a stable value. The edge-node hold property compares rd_data only across cycles with an unchanged rd_addr.
- Outside a run, only a start or an edge write alters the storage.

The stimulus keeps within these assumptions. It moves rd_addr only after a run has finished, and it issues writes and start pulses on separate falling edges. The mid-run start and write deliberately test that both are ignored. The bench uses a full 256-node readout after each run, compared with an arithmetic model of both update styles in both scan orders. This readout covers every node, including the rim.

// File: rtl/relax_pkg.sv
package relax_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;

  // True for nodes on the outer ring of a g x g mesh.
  function automatic logic is_rim(int idx, int g);
    int r;
    int c;
    r = idx / g;
    c = idx % g;
    return (r == 0) || (r == g - 1) || (c == 0) || (c == g - 1);
  endfunction

endpackage

// File: rtl/relax_grid_store.sv
module relax_grid_store
  import relax_pkg::*;
#(
  parameter int GRID = 16,
  parameter int W    = 16,
  parameter logic [W-1:0] TOP_V  = '0,
  parameter logic [W-1:0] BOT_V  = '0,
  parameter logic [W-1:0] SIDE_V = '0,
  localparam int N  = GRID * GRID,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bw_en,
  input  logic [AW-1:0] bw_addr,
  input  logic [W-1:0]  bw_data,
  input  logic          uw_en,
  input  logic          uw_bank,
  input  logic [AW-1:0] uw_addr,
  input  logic [W-1:0]  uw_data,
  input  logic          rbank,
  input  logic [AW-1:0] ra_n,
  input  logic [AW-1:0] ra_s,
  input  logic [AW-1:0] ra_e,
  input  logic [AW-1:0] ra_w,
  input  logic [AW-1:0] ra_c,
  output logic [W-1:0]  rv_n,
  output logic [W-1:0]  rv_s,
  output logic [W-1:0]  rv_e,
  output logic [W-1:0]  rv_w,
  output logic [W-1:0]  rv_c,
  input  logic [AW-1:0] ro_addr,
  output logic [W-1:0]  ro_data
);

  function automatic logic [W-1:0] init_val(int i);
    int r;
    int c;
    r = i / GRID;
    c = i % GRID;
    if (r == 0)             return TOP_V;
    else if (r == GRID - 1) return BOT_V;
    else if (c == 0 || c == GRID - 1) return SIDE_V;
    else                    return '0;
  endfunction

  logic [W-1:0] mem [2][N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++)
          mem[b][i] <= init_val(i);
    end else begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < N; i++) begin
          if (clr && !is_rim(i, GRID))
            mem[b][i] <= '0;
          else if (bw_en && bw_addr == AW'(i) && is_rim(i, GRID))
            mem[b][i] <= bw_data;
          else if (uw_en && uw_bank == 1'(b) && uw_addr == AW'(i))
            mem[b][i] <= uw_data;
        end
      end
    end
  end

  assign rv_n    = mem[rbank][ra_n];
  assign rv_s    = mem[rbank][ra_s];
  assign rv_e    = mem[rbank][ra_e];
  assign rv_w    = mem[rbank][ra_w];
  assign rv_c    = mem[rbank][ra_c];
  assign ro_data = mem[rbank][ro_addr];

endmodule

// File: rtl/relax_scan.sv
module relax_scan #(
  parameter int GRID = 16,
  localparam int RW = $clog2(GRID)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          rev_in,
  input  logic          adv,
  output logic [RW-1:0] row,
  output logic [RW-1:0] col,
  output logic          last
);

  localparam logic [RW-1:0] LO = RW'(1);
  localparam logic [RW-1:0] HI = RW'(GRID - 2);

  logic [RW-1:0] row_q, row_d, col_q, col_d;
  logic          rev_q, rev_d;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    rev_d = rev_q;
    if (load) begin
      rev_d = rev_in;
      row_d = rev_in ? HI : LO;
      col_d = rev_in ? HI : LO;
    end else if (adv) begin
      if (!rev_q) begin
        if (col_q == HI) begin
          col_d = LO;
          row_d = (row_q == HI) ? LO : row_q + RW'(1);
        end else begin
          col_d = col_q + RW'(1);
        end
      end else begin
        if (col_q == LO) begin
          col_d = HI;
          row_d = (row_q == LO) ? HI : row_q - RW'(1);
        end else begin
          col_d = col_q - RW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= LO;
      col_q <= LO;
      rev_q <= 1'b0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
      rev_q <= rev_d;
    end
  end

  assign row  = row_q;
  assign col  = col_q;
  assign last = rev_q ? (row_q == LO && col_q == LO) : (row_q == HI && col_q == HI);

endmodule

// File: rtl/relax_core.sv
module relax_core #(
  parameter int W      = 16,
  parameter int TOL_SH = 10
) (
  input  logic [W-1:0] nb_n,
  input  logic [W-1:0] nb_s,
  input  logic [W-1:0] nb_e,
  input  logic [W-1:0] nb_w,
  input  logic [W-1:0] old_v,
  output logic [W-1:0] new_v,
  output logic         big_chg
);

  logic [W+1:0] sum;
  logic [W-1:0] diff;
  logic [W-1:0] tol;

  always_comb begin
    sum     = {2'b00, nb_n} + {2'b00, nb_s} + {2'b00, nb_e} + {2'b00, nb_w};
    new_v   = sum[W+1:2];
    diff    = (new_v >= old_v) ? (new_v - old_v) : (old_v - new_v);
    tol     = old_v >> TOL_SH;
    big_chg = diff > tol;
  end

endmodule

// File: rtl/grid_relax.sv
module grid_relax
  import relax_pkg::*;
#(
  parameter int GRID   = 16,
  parameter int W      = 16,
  parameter int ITW    = 8,
  parameter int TOL_SH = 10,
  parameter logic [W-1:0] TOP_V  = 16'h0000,
  parameter logic [W-1:0] BOT_V  = 16'h1400,
  parameter logic [W-1:0] SIDE_V = 16'h0A00,
  localparam int AW = $clog2(GRID * GRID),
  localparam int RW = $clog2(GRID)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode_inplace,
  input  logic           scan_rev,
  input  logic           conv_en,
  input  logic [ITW-1:0] iter_cnt,
  input  logic           bnd_we,
  input  logic [AW-1:0]  bnd_addr,
  input  logic [W-1:0]   bnd_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [W-1:0]   rd_data,
  output logic           busy,
  output logic           done
);

  localparam logic [AW-1:0] STRIDE = AW'(GRID);

  run_state_e     st_q, st_d;
  logic           cur_q, cur_d;
  logic [ITW-1:0] iter_q, iter_d;
  logic [ITW-1:0] itc_q, itc_d;
  logic           inpl_q, inpl_d;
  logic           conv_q, conv_d;
  logic           chg_q, chg_d;
  logic           done_q, done_d;

  logic           run;
  logic           accept;
  logic [RW-1:0]  row, col;
  logic           last;
  logic [AW-1:0]  a_c, a_n, a_s, a_e, a_w;
  logic [W-1:0]   v_n, v_s, v_e, v_w, v_c;
  logic [W-1:0]   v_new;
  logic           big;
  logic           limit_hit;
  logic           stop;

  assign run    = (st_q == ST_RUN);
  assign accept = start & ~run;

  relax_scan #(.GRID(GRID)) u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept),
    .rev_in (scan_rev),
    .adv    (run),
    .row    (row),
    .col    (col),
    .last   (last)
  );

  always_comb begin
    a_c = AW'(row) * STRIDE + AW'(col);
    a_n = a_c - STRIDE;
    a_s = a_c + STRIDE;
    a_w = a_c - AW'(1);
    a_e = a_c + AW'(1);
  end

  relax_grid_store #(
    .GRID(GRID), .W(W), .TOP_V(TOP_V), .BOT_V(BOT_V), .SIDE_V(SIDE_V)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .bw_en   (bnd_we & ~run),
    .bw_addr (bnd_addr),
    .bw_data (bnd_data),
    .uw_en   (run),
    .uw_bank (inpl_q ? cur_q : ~cur_q),
    .uw_addr (a_c),
    .uw_data (v_new),
    .rbank   (cur_q),
    .ra_n    (a_n),
    .ra_s    (a_s),
    .ra_e    (a_e),
    .ra_w    (a_w),
    .ra_c    (a_c),
    .rv_n    (v_n),
    .rv_s    (v_s),
    .rv_e    (v_e),
    .rv_w    (v_w),
    .rv_c    (v_c),
    .ro_addr (rd_addr),
    .ro_data (rd_data)
  );

  relax_core #(.W(W), .TOL_SH(TOL_SH)) u_core (
    .nb_n    (v_n),
    .nb_s    (v_s),
    .nb_e    (v_e),
    .nb_w    (v_w),
    .old_v   (v_c),
    .new_v   (v_new),
    .big_chg (big)
  );

  assign limit_hit = ({1'b0, iter_q} + (ITW+1)'(1)) >= {1'b0, itc_q};
  assign stop      = limit_hit | (conv_q & ~(chg_q | big));

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    iter_d = iter_q;
    itc_d  = itc_q;
    inpl_d = inpl_q;
    conv_d = conv_q;
    chg_d  = chg_q;
    done_d = 1'b0;
    if (!run) begin
      if (start) begin
        st_d   = ST_RUN;
        cur_d  = 1'b0;
        iter_d = '0;
        itc_d  = iter_cnt;
        inpl_d = mode_inplace;
        conv_d = conv_en;
        chg_d  = 1'b0;
      end
    end else begin
      chg_d = chg_q | big;
      if (last) begin
        iter_d = iter_q + ITW'(1);
        chg_d  = 1'b0;
        if (!inpl_q) cur_d = ~cur_q;
        if (stop) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= 1'b0;
      iter_q <= '0;
      itc_q  <= '0;
      inpl_q <= 1'b0;
      conv_q <= 1'b0;
      chg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      iter_q <= iter_d;
      itc_q  <= itc_d;
      inpl_q <= inpl_d;
      conv_q <= conv_d;
      chg_q  <= chg_d;
      done_q <= done_d;
    end
  end

  assign busy = run;
  assign done = done_q;

endmodule

// File: rtl/grid_relax_chk.sv
module grid_relax_chk
  import relax_pkg::*;
#(
  parameter int GRID = 16,
  parameter int W    = 16,
  localparam int AW = $clog2(GRID * GRID)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          bnd_we,
  input logic [AW-1:0] rd_addr,
  input logic [W-1:0]  rd_data,
  input logic          busy,
  input logic          done
);

  logic armed_q;
  logic rim_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_comb rim_sel = is_rim(int'(rd_addr), GRID);

  // R12
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $fell(busy)) |-> done);

  // R3
  rim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && busy && $past(busy) && $stable(rd_addr) && rim_sel) |-> $stable(rd_data));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !busy && !$past(busy) && !$past(start) && !$past(bnd_we) && $stable(rd_addr))
      |-> $stable(rd_data));

endmodule

bind grid_relax grid_relax_chk #(.GRID(GRID), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .bnd_we  (bnd_we),
  .rd_addr (rd_addr),
  .rd_data (rd_data),
  .busy    (busy),
  .done    (done)
);

// File: tb/sim_grid_relax.sv
`timescale 1ns/1ps
module sim_grid_relax;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        mode_inplace;
  logic        scan_rev;
  logic        conv_en;
  logic [7:0]  iter_cnt;
  logic        bnd_we;
  logic [7:0]  bnd_addr;
  logic [15:0] bnd_data;
  logic [7:0]  rd_addr;
  logic [15:0] rd_data;
  logic        busy;
  logic        done;

  int vecs;
  int fails;
  int expg [16][16];
  int snap [16][16];

  grid_relax u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_inplace(mode_inplace),
    .scan_rev(scan_rev), .conv_en(conv_en), .iter_cnt(iter_cnt),
    .bnd_we(bnd_we), .bnd_addr(bnd_addr), .bnd_data(bnd_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #950000;
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit rim(int r, int c);
    return (r == 0) || (r == 15) || (c == 0) || (c == 15);
  endfunction

  task automatic model_reset();
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        if (r == 0) expg[r][c] = 0;
        else if (r == 15) expg[r][c] = 'h1400;
        else if (c == 0 || c == 15) expg[r][c] = 'h0A00;
        else expg[r][c] = 0;
      end
  endtask

  // Arithmetic model of the requirements R4..R10; returns sweeps performed.
  task automatic model_run(input bit inpl, input bit rev, input bit conv, input int itc,
                           output int sweeps);
    int lim;
    bit chg;
    lim = (itc < 1) ? 1 : itc;
    sweeps = 0;
    for (int r = 1; r < 15; r++)
      for (int c = 1; c < 15; c++) expg[r][c] = 0;
    forever begin
      snap = expg;
      chg = 0;
      for (int k = 0; k < 196; k++) begin
        int r, c, sum, nv, ov, d;
        r = rev ? 14 - k / 14 : 1 + k / 14;
        c = rev ? 14 - k % 14 : 1 + k % 14;
        if (inpl) sum = expg[r-1][c] + expg[r+1][c] + expg[r][c-1] + expg[r][c+1];
        else      sum = snap[r-1][c] + snap[r+1][c] + snap[r][c-1] + snap[r][c+1];
        nv = sum >> 2;
        ov = snap[r][c];
        d  = (nv >= ov) ? nv - ov : ov - nv;
        if (d > (ov >> 10)) chg = 1;
        expg[r][c] = nv;
      end
      sweeps++;
      if (sweeps >= lim || (conv && !chg)) break;
    end
  endtask

  task automatic check_grid(input string req);
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      rd_addr = 8'(a);
      #1;
      chk(rd_data == 16'(expg[a/16][a%16]), req, int'(rd_data), expg[a/16][a%16]);
    end
  endtask

  task automatic wr_node(input int r, input int c, input int v);
    @(negedge clk);
    bnd_we = 1'b1; bnd_addr = 8'(r*16 + c); bnd_data = 16'(v);
    @(negedge clk);
    bnd_we = 1'b0;
    if (rim(r, c)) expg[r][c] = v;
  endtask

  task automatic run(input bit inpl, input bit rev, input bit conv, input int itc,
                     input bit glitch, input string req);
    int sweeps;
    int cnt;
    model_run(inpl, rev, conv, itc, sweeps);
    @(negedge clk);
    start = 1'b1; mode_inplace = inpl; scan_rev = rev; conv_en = conv; iter_cnt = 8'(itc);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, req, int'(busy), 1);
    cnt = 0;
    while (!done && cnt < 60000) begin
      @(negedge clk);
      cnt++;
      if (glitch && cnt == 50) begin
        // R11: start, config and a rim write mid-run must be ignored
        start = 1'b1; mode_inplace = ~inpl; scan_rev = ~rev; iter_cnt = 8'd9;
        bnd_we = 1'b1; bnd_addr = 8'd3; bnd_data = 16'h7777;
      end
      if (glitch && cnt == 51) begin
        start = 1'b0; bnd_we = 1'b0;
      end
    end
    // R9: latency of sweeps * 196 cycles, busy falls with done
    chk(cnt == sweeps * 196, "R9 latency", cnt, sweeps * 196);
    chk(busy == 1'b0, "R12 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R12 done one cycle", int'(done), 0);
    check_grid(req);
  endtask

  initial begin
    vecs = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; mode_inplace = 1'b0; scan_rev = 1'b0; conv_en = 1'b0;
    iter_cnt = 8'd5; bnd_we = 1'b0; bnd_addr = '0; bnd_data = '0; rd_addr = '0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    check_grid("R1 reset grid");

    // R2: rim writes land, interior write ignored
    wr_node(0, 3, 'h1234);
    wr_node(7, 0, 'h0100);
    wr_node(5, 5, 'h4444);
    check_grid("R2 idle writes");

    run(1'b0, 1'b0, 1'b0, 5, 1'b0, "R6 R5 buffered fwd");
    run(1'b1, 1'b0, 1'b0, 5, 1'b0, "R7 inplace fwd");
    run(1'b1, 1'b1, 1'b0, 5, 1'b0, "R8 inplace rev");
    run(1'b0, 1'b1, 1'b0, 1, 1'b0, "R6 buffered rev");
    run(1'b1, 1'b0, 1'b0, 0, 1'b0, "R9 count zero");
    model_reset();
    wr_node(0, 3, 0);
    wr_node(7, 0, 'h0A00);
    wr_node(0, 1, 'h1400);
    run(1'b1, 1'b0, 1'b0, 5, 1'b0, "R4 R3 rerun clears");
    run(1'b1, 1'b0, 1'b1, 200, 1'b0, "R10 conv inplace");
    run(1'b0, 1'b0, 1'b1, 200, 1'b0, "R10 conv buffered");
    run(1'b1, 1'b1, 1'b0, 2, 1'b1, "R11 ignored while busy");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule